// File: doc/BRIEF.md
# Host Bus Link-Adapter Glue

This block sits between an 8-bit home-computer expansion bus and a byte-wide serial-link adapter. It also drives the control lines of the attached processor module. It decodes a 16-byte address window. Four locations in that window go through to the adapter's own registers: the received byte, the byte to transmit, and the input and output status registers. Two further locations are local: a reset register and an analyse register. The block holds the reset and analyse outputs in latches and returns the module's error line when the reset location is read.

The window is placed in one of two ways. In cartridge mode it sits at a fixed base. In slot mode its base is computed from the number of the slot the card is plugged into. The adapter's control lines and the module's control lines are active low on the pins. The block inverts them, so software always reads and writes positive-sense bits.

A bus access is a level on `busAcc` that may last one or more clocks. The adapter receives one strobe, in the first clock of the access. Read data is returned combinationally for as long as the access lasts.

Top module: `lnkglue_top`

## Requirements
- R1: A read at window offset 0 gives the adapter one read strobe with register select 0 and returns the adapter's data byte on the bus.
- R2: A write at window offset 1 gives the adapter one write strobe with register select 1, carrying the bus write byte.
- R3: Reads and writes at offsets 2 and 3 reach the adapter's status registers with register select 2 and 3, passing data unchanged in both directions. This means bit 0, the ready flag, is returned as is, and a written 0 reaches the adapter to clear its interrupt enable.
- R4: A write at offset 8 loads bit 0 of the written byte into the reset latch, and `lnkResetN` is the inverse of that latch. Writing 1 and then 0 produces a reset pulse.
- R5: A read at offset 8 returns the inverted `lnkErrorN` on bit 0 and zeros on bits 7..1.
- R6: A write at offset 12 loads bit 0 into the analyse latch, and `lnkAnalyseN` is the inverse of that latch.
- R7: With `slotMode`=1 the window base is 0xC080 + 16*`slotNum`. With `slotMode`=0 it is 0xDE00. An access outside the window produces no strobe, reads 0 and leaves both latches unchanged.
- R8: Undecoded accesses read 0 and are ignored. These are: a write at offset 0, a read at offset 1, any access at offsets 4-7, 9-11 and 13-15, and a read at offset 12.
- R9: After reset, `lnkResetN` and `lnkAnalyseN` are 1 (deasserted) and no adapter strobe is active.
- R10: An adapter access, however many clocks long, asserts `adpCsN` for exactly one clock, the first clock of the access. `adpRs` always equals address bits 1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| slotMode | input | 1 | 1 = slot-derived base, 0 = fixed cartridge base |
| slotNum | input | 3 | Slot number used in slot mode |
| busAcc | input | 1 | Bus access in progress (level) |
| busWr | input | 1 | 1 = write access, 0 = read access |
| busAddr | input | 16 | Bus address |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Bus read data (0 when nothing is selected) |
| adpCsN | output | 1 | Adapter chip select, active low |
| adpRdN | output | 1 | Adapter read strobe, active low |
| adpWrN | output | 1 | Adapter write strobe, active low |
| adpRs | output | 2 | Adapter register select |
| adpWdata | output | 8 | Data to the adapter |
| adpRdata | input | 8 | Data from the adapter |
| lnkResetN | output | 1 | Module reset line, active low |
| lnkAnalyseN | output | 1 | Module analyse line, active low |
| lnkErrorN | input | 1 | Module error line, active low |

## Verification
The assertions check, in every cycle, properties that need no knowledge of the address map:
- a chip select lasts a single clock;
- read and write strobes are exclusive and always come with the chip select;
- no strobe appears and read data is zero when no access is in progress;
- the reset and analyse lines change only after a write access.

Only the bench scenarios can show the address map itself. These cover the two base computations, offsets at the window edges, the inverted error readback, the reset pulse sequence, and long accesses that must still strobe once. The bench compares them against an address model of its own.

// File: rtl/lnkglue_pkg.sv
`timescale 1ns/1ps
package lnkglue_pkg;
  localparam int WIN_BITS = 4;

  localparam logic [WIN_BITS-1:0] OFF_RXDATA  = 4'd0;
  localparam logic [WIN_BITS-1:0] OFF_TXDATA  = 4'd1;
  localparam logic [WIN_BITS-1:0] OFF_ISTAT   = 4'd2;
  localparam logic [WIN_BITS-1:0] OFF_OSTAT   = 4'd3;
  localparam logic [WIN_BITS-1:0] OFF_RESET   = 4'd8;
  localparam logic [WIN_BITS-1:0] OFF_ANALYSE = 4'd12;

  typedef enum logic [1:0] {RD_NONE = 2'd0, RD_ADP = 2'd1, RD_ERR = 2'd2} rdSrc_t;

  typedef struct packed {
    logic   adpRd;
    logic   adpWr;
    logic   rstWr;
    logic   anaWr;
    rdSrc_t rdSrc;
  } glueCtl_t;
endpackage

// File: rtl/lnkglue_ctrl.sv
`timescale 1ns/1ps
module lnkglue_ctrl
  import lnkglue_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 3,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 16'hC080,
  parameter logic [ADDR_W-1:0] CART_BASE = 16'hDE00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slotMode,
  input  logic [SLOT_W-1:0] slotNum,
  input  logic              busAcc,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output glueCtl_t          ctl
);
  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic              accPrev;
  logic              accStart;
  logic [ADDR_W-1:0] slotBase;
  logic [ADDR_W-1:0] winBase;
  logic              winHit;
  logic [WIN_BITS-1:0] off;

  always_ff @(posedge clk) begin
    if (rst) accPrev <= 1'b0;
    else     accPrev <= busAcc;
  end

  assign accStart = busAcc && !accPrev;
  assign slotBase = SLOT_BASE + (ADDR_W'(slotNum) << WIN_BITS);
  assign winBase  = slotMode ? slotBase : CART_BASE;
  assign winHit   = busAddr[ADDR_W-1 -: TAG_W] == winBase[ADDR_W-1 -: TAG_W];
  assign off      = busAddr[WIN_BITS-1:0];

  always_comb begin
    ctl = '0;
    if (busAcc && winHit) begin
      case (off)
        OFF_RXDATA: if (!busWr) begin
          ctl.adpRd = accStart;
          ctl.rdSrc = RD_ADP;
        end
        OFF_TXDATA: if (busWr) ctl.adpWr = accStart;
        OFF_ISTAT, OFF_OSTAT: begin
          if (busWr) ctl.adpWr = accStart;
          else begin
            ctl.adpRd = accStart;
            ctl.rdSrc = RD_ADP;
          end
        end
        OFF_RESET: begin
          if (busWr) ctl.rstWr = accStart;
          else       ctl.rdSrc = RD_ERR;
        end
        OFF_ANALYSE: if (busWr) ctl.anaWr = accStart;
        default: ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/lnkglue_dp.sv
`timescale 1ns/1ps
module lnkglue_dp
  import lnkglue_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  glueCtl_t          ctl,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] adpRdata,
  output logic              adpCsN,
  output logic              adpRdN,
  output logic              adpWrN,
  output logic [DATA_W-1:0] adpWdata,
  input  logic              lnkErrorN,
  output logic              lnkResetN,
  output logic              lnkAnalyseN
);
  logic rstLat;
  logic anaLat;

  always_ff @(posedge clk) begin
    if (rst) begin
      rstLat <= 1'b0;
      anaLat <= 1'b0;
    end else begin
      if (ctl.rstWr) rstLat <= busWdata[0];
      if (ctl.anaWr) anaLat <= busWdata[0];
    end
  end

  always_comb begin
    case (ctl.rdSrc)
      RD_ADP:  busRdata = adpRdata;
      RD_ERR:  busRdata = {{(DATA_W-1){1'b0}}, ~lnkErrorN};
      default: busRdata = '0;
    endcase
  end

  assign adpCsN      = !(ctl.adpRd || ctl.adpWr);
  assign adpRdN      = !ctl.adpRd;
  assign adpWrN      = !ctl.adpWr;
  assign adpWdata    = busWdata;
  assign lnkResetN   = !rstLat;
  assign lnkAnalyseN = !anaLat;
endmodule

// File: rtl/lnkglue_top.sv
`timescale 1ns/1ps
module lnkglue_top
  import lnkglue_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SLOT_W = 3,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 16'hC080,
  parameter logic [ADDR_W-1:0] CART_BASE = 16'hDE00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slotMode,
  input  logic [SLOT_W-1:0] slotNum,
  input  logic              busAcc,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              adpCsN,
  output logic              adpRdN,
  output logic              adpWrN,
  output logic [1:0]        adpRs,
  output logic [DATA_W-1:0] adpWdata,
  input  logic [DATA_W-1:0] adpRdata,
  output logic              lnkResetN,
  output logic              lnkAnalyseN,
  input  logic              lnkErrorN
);
  glueCtl_t ctl;

  lnkglue_ctrl #(
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W),
    .SLOT_BASE(SLOT_BASE), .CART_BASE(CART_BASE)
  ) ctrl_i (
    .clk(clk), .rst(rst), .slotMode(slotMode), .slotNum(slotNum),
    .busAcc(busAcc), .busWr(busWr), .busAddr(busAddr), .ctl(ctl)
  );

  lnkglue_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .ctl(ctl),
    .busWdata(busWdata), .busRdata(busRdata), .adpRdata(adpRdata),
    .adpCsN(adpCsN), .adpRdN(adpRdN), .adpWrN(adpWrN), .adpWdata(adpWdata),
    .lnkErrorN(lnkErrorN), .lnkResetN(lnkResetN), .lnkAnalyseN(lnkAnalyseN)
  );

  assign adpRs = busAddr[1:0];
endmodule

// File: rtl/lnkglue_chk.sv
`timescale 1ns/1ps
module lnkglue_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busAcc,
  input logic              busWr,
  input logic [DATA_W-1:0] busRdata,
  input logic              adpCsN,
  input logic              adpRdN,
  input logic              adpWrN,
  input logic              lnkResetN,
  input logic              lnkAnalyseN
);
  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
    !adpCsN |=> adpCsN);                                             // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!adpRdN && !adpWrN));                                          // R1
  AST_STROBE_HAS_SELECT: assert property (@(posedge clk) disable iff (rst)
    (!adpRdN || !adpWrN) |-> !adpCsN);                               // R2
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !busAcc |-> (adpCsN && busRdata == '0));                         // R8
  AST_RESET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(busAcc && busWr) |=> $stable(lnkResetN));                      // R4
  AST_ANALYSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(busAcc && busWr) |=> $stable(lnkAnalyseN));                    // R6
endmodule

bind lnkglue_top lnkglue_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .busAcc(busAcc), .busWr(busWr), .busRdata(busRdata),
  .adpCsN(adpCsN), .adpRdN(adpRdN), .adpWrN(adpWrN),
  .lnkResetN(lnkResetN), .lnkAnalyseN(lnkAnalyseN)
);

// File: tb/lnkglue_tb.sv
`timescale 1ns/1ps
module lnkglue_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slotMode = 1'b0;
  logic [2:0]  slotNum = '0;
  logic        busAcc = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        adpCsN, adpRdN, adpWrN;
  logic [1:0]  adpRs;
  logic [7:0]  adpWdata;
  logic [7:0]  adpRdata;
  logic        lnkResetN, lnkAnalyseN;
  logic        lnkErrorN = 1'b1;

  int nChk = 0;
  int nFail = 0;
  logic expRst = 1'b0;
  logic expAna = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] adpModel(logic [1:0] rs);
    return 8'h3C ^ {rs, 4'h5, rs};
  endfunction

  always_comb adpRdata = adpModel(adpRs);

  lnkglue_top dut_i (
    .clk(clk), .rst(rst), .slotMode(slotMode), .slotNum(slotNum),
    .busAcc(busAcc), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .adpCsN(adpCsN), .adpRdN(adpRdN), .adpWrN(adpWrN), .adpRs(adpRs),
    .adpWdata(adpWdata), .adpRdata(adpRdata),
    .lnkResetN(lnkResetN), .lnkAnalyseN(lnkAnalyseN), .lnkErrorN(lnkErrorN)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] baseOf(logic m, logic [2:0] s);
    return m ? (16'hC080 + 16'(s) * 16'd16) : 16'hDE00;
  endfunction

  function automatic string reqOf(bit hit, logic [3:0] off, logic w);
    if (!hit) return "R7";
    case (off)
      4'd0: return w ? "R8" : "R1";
      4'd1: return w ? "R2" : "R8";
      4'd2, 4'd3: return "R3";
      4'd8: return w ? "R4" : "R5";
      4'd12: return w ? "R6" : "R8";
      default: return "R8";
    endcase
  endfunction

  task automatic doAcc(input logic [15:0] a, input logic w, input logic [7:0] d,
                       input int len);
    logic [7:0] rd;
    int nStb;
    logic sRd, sWr;
    logic [1:0] sRs;
    logic [7:0] sWd;
    bit hit;
    logic [3:0] off;
    bit expStb;
    logic [7:0] expRd;
    string rq;
    logic [15:0] b;
    b = baseOf(slotMode, slotNum);
    hit = a[15:4] == b[15:4];
    off = a[3:0];
    expStb = hit && ((w && (off == 1 || off == 2 || off == 3)) ||
                     (!w && (off == 0 || off == 2 || off == 3)));
    expRd = 8'h00;
    if (hit && !w) begin
      if (off == 0 || off == 2 || off == 3) expRd = adpModel(off[1:0]);
      else if (off == 8) expRd = {7'b0, ~lnkErrorN};
    end
    if (hit && w && off == 8) expRst = d[0];
    if (hit && w && off == 12) expAna = d[0];
    rq = reqOf(hit, off, w);
    nStb = 0; sRd = 0; sWr = 0; sRs = '0; sWd = '0; rd = '0;
    @(negedge clk);
    busAddr = a; busWr = w; busWdata = d; busAcc = 1'b1;
    for (int i = 0; i < len; i++) begin
      #1;
      if (i == 0) rd = busRdata;
      if (!adpCsN) begin
        nStb++;
        sRd = !adpRdN; sWr = !adpWrN; sRs = adpRs; sWd = adpWdata;
      end
      @(negedge clk);
    end
    busAcc = 1'b0; busWr = 1'b0;
    @(negedge clk);
    chk(nStb == (expStb ? 1 : 0), "R10", "strobe count", nStb, expStb ? 1 : 0);
    if (expStb) begin
      chk(sRd == !w && sWr == w, rq, "strobe kind", {sRd, sWr}, {!w, w});
      chk(sRs == off[1:0], rq, "register select", sRs, off[1:0]);
      if (w) chk(sWd == d, rq, "adapter write data", sWd, d);
    end
    if (!w) chk(rd == expRd, rq, "read data", rd, expRd);
    chk(lnkResetN == !expRst, rq, "reset line", lnkResetN, !expRst);
    chk(lnkAnalyseN == !expAna, rq, "analyse line", lnkAnalyseN, !expAna);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic [15:0] b;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    // R9 state while reset is held and just after
    chk(lnkResetN && lnkAnalyseN, "R9", "lines in reset", {lnkResetN, lnkAnalyseN}, 2'b11);
    chk(adpCsN && adpRdN && adpWrN, "R9", "strobes in reset", {adpCsN, adpRdN, adpWrN}, 3'b111);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    chk(lnkResetN && lnkAnalyseN, "R9", "lines after reset", {lnkResetN, lnkAnalyseN}, 2'b11);
    chk(busRdata == 8'h00, "R9", "idle read data", busRdata, 0);

    // cartridge mode, directed
    slotMode = 1'b0;
    doAcc(16'hDE00, 1'b0, 8'h00, 1);          // R1
    doAcc(16'hDE01, 1'b1, 8'hA5, 1);          // R2
    doAcc(16'hDE02, 1'b0, 8'h00, 1);          // R3
    doAcc(16'hDE03, 1'b1, 8'h00, 1);          // R3 clear enable
    doAcc(16'hDE08, 1'b1, 8'h01, 1);          // R4 pulse start
    doAcc(16'hDE08, 1'b1, 8'h00, 2);          // R4 pulse end
    lnkErrorN = 1'b0;
    doAcc(16'hDE08, 1'b0, 8'h00, 1);          // R5 error set
    lnkErrorN = 1'b1;
    doAcc(16'hDE08, 1'b0, 8'h00, 1);          // R5 error clear
    doAcc(16'hDE0C, 1'b1, 8'hFF, 1);          // R6
    doAcc(16'hDE0C, 1'b0, 8'h00, 1);          // R8 read of analyse
    doAcc(16'hDE05, 1'b1, 8'hFF, 1);          // R8
    doAcc(16'hDE0F, 1'b0, 8'h00, 1);          // R8
    doAcc(16'hDE00, 1'b1, 8'h11, 1);          // R8 write at rx offset
    doAcc(16'hDE10, 1'b1, 8'h01, 1);          // R7 just above
    doAcc(16'hDDF8, 1'b1, 8'h01, 1);          // R7 just below
    doAcc(16'hDE00, 1'b0, 8'h00, 5);          // R10 long access
    doAcc(16'hDE01, 1'b1, 8'h3C, 4);          // R10 long write

    // slot mode, directed edges
    slotMode = 1'b1; slotNum = 3'd0;
    doAcc(16'hC080, 1'b0, 8'h00, 1);          // R7 slot 0
    doAcc(16'hDE08, 1'b1, 8'h01, 1);          // R7 cartridge address now a miss
    slotNum = 3'd7;
    doAcc(16'hC0F8, 1'b1, 8'h01, 1);          // R7 slot 7 reset
    doAcc(16'hC0F8, 1'b1, 8'h00, 1);
    doAcc(16'hC080, 1'b0, 8'h00, 1);          // R7 slot 0 address now a miss

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      int pick;
      slotMode = 1'($urandom);
      slotNum = 3'($urandom);
      lnkErrorN = 1'($urandom);
      b = baseOf(slotMode, slotNum);
      pick = int'($urandom % 4);
      case (pick)
        0: a = b + 16'($urandom % 16);
        1: a = b + ((($urandom % 2) == 0) ? 16'd8 : 16'd12);
        2: a = 16'($urandom);
        default: a = baseOf(!slotMode, 3'($urandom)) + 16'($urandom % 16);
      endcase
      doAcc(a, 1'($urandom), 8'($urandom), 1 + int'($urandom % 3));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule